// File: doc/BRIEF.md
# Masked AND-weight accumulator

This block finds the Hamming weight of the bitwise AND of two secret bit vectors without ever holding either vector, or the AND result, in unmasked form. Each operand arrives one 32-bit word per cycle, split into three Boolean shares. A three-share threshold AND stage produces three Boolean shares of the product word. Refresh vectors re-mask those shares, and the refresh vectors are built almost entirely from shifted shares of the second operand, so only two fresh random bits are drawn per word.

Each product bit's three Boolean shares are then turned into two arithmetic shares modulo 64. Each bit lane adds its pair into a counter pair of its own. Once a fixed number of words has been accepted, the counter pairs are folded into a two-share arithmetic total, and a one-cycle done pulse announces it. The true weight of a run is assumed to stay below 64, so every counter and the total are kept modulo 64. Callers that need a threshold decision compare the recombined total outside this block.

A run starts with the first accepted word after reset or after the previous result. Words are accepted only while a run is open. The product shares are also brought out, one cycle after each accepted word, so that their recombination can be observed.

Top module: `masked_and_weight`

## Requirements
- R1: After reset, done, prod_valid, total_a and total_b are all 0.
- R2: One clock after a word is accepted, prod_valid is 1 and prod_sh1 ^ prod_sh2 ^ prod_sh3 equals (x_sh1 ^ x_sh2 ^ x_sh3) & (y_sh1 ^ y_sh2 ^ y_sh3) of that word. In every cycle in which no word was accepted on the previous edge, prod_valid is 0.
- R3: The product shares have exact values. With xi = x_shi and yi = y_shi: f1 = x2&y2 ^ x2&y3 ^ x3&y2, f2 = x3&y3 ^ x1&y3 ^ x3&y1, f3 = x1&y1 ^ x1&y2 ^ x2&y1. The refresh vectors are r1 = {y2[30:0], c1} and r2 = {y3[30:0], c2}, where c1 = fresh_bits[0] ^ (bit 31 of y_sh2 of the previously accepted word) and c2 = fresh_bits[1] ^ (bit 31 of y_sh3 of that word). Both carried bits are 0 after reset. The outputs are prod_sh1 = f1^r1, prod_sh2 = f2^r2 and prod_sh3 = f3^r1^r2.
- R4: The accepted word that completes NUM_WORDS (150) words of a run is followed, on the third clock edge counting its own acceptance edge as the first, by done = 1 for exactly one cycle. At that point (total_a + total_b) mod 64 equals the popcount of all AND words of the run.
- R5: Cycles with in_valid low inside a run are not counted, and they do not change the result.
- R6: in_valid is ignored on the two edges after a run's last word, while the run is being closed. Those words produce no prod_valid and do not count toward the next run.
- R7: total_a and total_b change only in a cycle in which done is 1, and they hold their value otherwise.
- R8: Bit lane i uses conv_rnd[6i+5:6i] in the cycle when its product shares are presented as its first arithmetic share. If conv_rnd is all zero throughout a run, total_a is 0 and total_b equals the weight.
- R9: Each run starts from cleared counters, so back-to-back runs give independent totals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word strobe |
| x_sh1 | input | 32 | Operand X Boolean share 1 |
| x_sh2 | input | 32 | Operand X Boolean share 2 |
| x_sh3 | input | 32 | Operand X Boolean share 3 |
| y_sh1 | input | 32 | Operand Y Boolean share 1 |
| y_sh2 | input | 32 | Operand Y Boolean share 2 |
| y_sh3 | input | 32 | Operand Y Boolean share 3 |
| fresh_bits | input | 2 | Fresh random bits for the refresh vectors |
| conv_rnd | input | 192 | Fresh randomness for Boolean-to-arithmetic conversion, 6 bits per lane |
| prod_valid | output | 1 | Product shares valid |
| prod_sh1 | output | 32 | Product Boolean share 1 |
| prod_sh2 | output | 32 | Product Boolean share 2 |
| prod_sh3 | output | 32 | Product Boolean share 3 |
| done | output | 1 | One-cycle pulse: new total |
| total_a | output | 6 | Arithmetic share A of the weight |
| total_b | output | 6 | Arithmetic share B of the weight |

## Verification
The hardest case to reach from the ports is a run whose weight sits at the edge of the modulo-64 range while the per-lane counter shares wrap many times. The stimulus picks the true operand words first, with an all-ones X and single-bit Y words, so that it can place the weight exactly, for example at 45 or at 0. It then splits those words into random shares and feeds random conversion values, which makes every counter share wrap. Two further cases take deliberate timing: strobes held high into the two closing edges after a run's last word, and a run fed with all-zero conversion randomness so that the split of the total between its two shares becomes visible.

// File: rtl/masked_and_weight_pkg.sv
package masked_and_weight_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_SUM   = 2'd3
    } phase_t;

endpackage

// File: rtl/mw_ti_and.sv
module mw_ti_and #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] x1,
    input  logic [WORD_W-1:0] x2,
    input  logic [WORD_W-1:0] x3,
    input  logic [WORD_W-1:0] y1,
    input  logic [WORD_W-1:0] y2,
    input  logic [WORD_W-1:0] y3,
    input  logic [1:0]        fresh,
    output logic              z_valid,
    output logic [WORD_W-1:0] z1,
    output logic [WORD_W-1:0] z2,
    output logic [WORD_W-1:0] z3
);

    logic              carry1, carry2;
    logic [WORD_W-1:0] f1, f2, f3;
    logic [WORD_W-1:0] ref1, ref2;

    // each component omits one share index
    always_comb begin
        f1   = (x2 & y2) ^ (x2 & y3) ^ (x3 & y2);
        f2   = (x3 & y3) ^ (x1 & y3) ^ (x3 & y1);
        f3   = (x1 & y1) ^ (x1 & y2) ^ (x2 & y1);
        ref1 = {y2[WORD_W-2:0], carry1 ^ fresh[0]};
        ref2 = {y3[WORD_W-2:0], carry2 ^ fresh[1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z_valid <= 1'b0;
            z1      <= '0;
            z2      <= '0;
            z3      <= '0;
            carry1  <= 1'b0;
            carry2  <= 1'b0;
        end else begin
            z_valid <= take;
            if (take) begin
                z1     <= f1 ^ ref1;
                z2     <= f2 ^ ref2;
                z3     <= f3 ^ ref1 ^ ref2;
                carry1 <= y2[WORD_W-1];
                carry2 <= y3[WORD_W-1];
            end
        end
    end

endmodule

// File: rtl/mw_count_bank.sv
module mw_count_bank #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           add_en,
    input  logic                           clear,
    input  logic [WORD_W-1:0]              s1,
    input  logic [WORD_W-1:0]              s2,
    input  logic [WORD_W-1:0]              s3,
    input  logic [WORD_W*CNT_W-1:0]        rnd,
    output logic [WORD_W-1:0][CNT_W-1:0]   cnt_a,
    output logic [WORD_W-1:0][CNT_W-1:0]   cnt_b
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar i = 0; i < WORD_W; i++) begin : g_lane
        logic             sel_p;
        logic [CNT_W-1:0] qv, rv, arm0, arm1, share_b;

        always_comb begin
            sel_p   = s1[i] ^ s2[i];
            qv      = {{(CNT_W-1){1'b0}}, s3[i]};
            rv      = rnd[i*CNT_W +: CNT_W];
            arm0    = qv - rv;
            arm1    = ONE - qv - rv;
            share_b = sel_p ? arm1 : arm0;
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                cnt_a[i] <= '0;
                cnt_b[i] <= '0;
            end else if (add_en) begin
                cnt_a[i] <= cnt_a[i] + rv;
                cnt_b[i] <= cnt_b[i] + share_b;
            end
        end
    end

endmodule

// File: rtl/mw_reduce.sv
module mw_reduce #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [WORD_W-1:0][CNT_W-1:0] cnt_a,
    input  logic [WORD_W-1:0][CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0]             sum_a,
    output logic [CNT_W-1:0]             sum_b
);

    always_comb begin
        sum_a = '0;
        sum_b = '0;
        for (int i = 0; i < WORD_W; i++) begin
            sum_a = sum_a + cnt_a[i];
            sum_b = sum_b + cnt_b[i];
        end
    end

endmodule

// File: rtl/masked_and_weight.sv
module masked_and_weight
    import masked_and_weight_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int CNT_W     = 6,
    parameter int NUM_WORDS = 150
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       x_sh1,
    input  logic [WORD_W-1:0]       x_sh2,
    input  logic [WORD_W-1:0]       x_sh3,
    input  logic [WORD_W-1:0]       y_sh1,
    input  logic [WORD_W-1:0]       y_sh2,
    input  logic [WORD_W-1:0]       y_sh3,
    input  logic [1:0]              fresh_bits,
    input  logic [WORD_W*CNT_W-1:0] conv_rnd,
    output logic                    prod_valid,
    output logic [WORD_W-1:0]       prod_sh1,
    output logic [WORD_W-1:0]       prod_sh2,
    output logic [WORD_W-1:0]       prod_sh3,
    output logic                    done,
    output logic [CNT_W-1:0]        total_a,
    output logic [CNT_W-1:0]        total_b
);

    localparam int WC_W = $clog2(NUM_WORDS + 1);
    localparam logic [WC_W-1:0] LAST_IDX = WC_W'(NUM_WORDS - 1);

    phase_t                      state, state_nx;
    logic [WC_W-1:0]             wcnt, wcnt_nx;
    logic                        take_word;
    logic                        clear_cnt;
    logic [WORD_W-1:0][CNT_W-1:0] cnt_a, cnt_b;
    logic [CNT_W-1:0]            sum_a, sum_b;

    // next state and control outputs
    always_comb begin
        state_nx  = state;
        wcnt_nx   = wcnt;
        take_word = 1'b0;
        clear_cnt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    take_word = 1'b1;
                    if (NUM_WORDS == 1) begin
                        state_nx = ST_FLUSH;
                        wcnt_nx  = '0;
                    end else begin
                        state_nx = ST_RUN;
                        wcnt_nx  = WC_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (in_valid) begin
                    take_word = 1'b1;
                    if (wcnt == LAST_IDX) begin
                        state_nx = ST_FLUSH;
                        wcnt_nx  = '0;
                    end else begin
                        wcnt_nx = wcnt + WC_W'(1);
                    end
                end
            end
            ST_FLUSH: begin
                state_nx = ST_SUM;
            end
            ST_SUM: begin
                clear_cnt = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // state register and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            done    <= 1'b0;
            total_a <= '0;
            total_b <= '0;
        end else begin
            state <= state_nx;
            wcnt  <= wcnt_nx;
            done  <= (state == ST_SUM);
            if (state == ST_SUM) begin
                total_a <= sum_a;
                total_b <= sum_b;
            end
        end
    end

    mw_ti_and #(.WORD_W(WORD_W)) u_and (
        .clk     (clk),
        .rst     (rst),
        .take    (take_word),
        .x1      (x_sh1),
        .x2      (x_sh2),
        .x3      (x_sh3),
        .y1      (y_sh1),
        .y2      (y_sh2),
        .y3      (y_sh3),
        .fresh   (fresh_bits),
        .z_valid (prod_valid),
        .z1      (prod_sh1),
        .z2      (prod_sh2),
        .z3      (prod_sh3)
    );

    mw_count_bank #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .add_en (prod_valid),
        .clear  (clear_cnt),
        .s1     (prod_sh1),
        .s2     (prod_sh2),
        .s3     (prod_sh3),
        .rnd    (conv_rnd),
        .cnt_a  (cnt_a),
        .cnt_b  (cnt_b)
    );

    mw_reduce #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_reduce (
        .cnt_a (cnt_a),
        .cnt_b (cnt_b),
        .sum_a (sum_a),
        .sum_b (sum_b)
    );

endmodule

// File: rtl/masked_and_weight_chk.sv
module masked_and_weight_chk #(
    parameter int WORD_W    = 32,
    parameter int CNT_W     = 6,
    parameter int NUM_WORDS = 150
) (
    input logic              clk,
    input logic              rst,
    input logic              take_word,
    input logic [WORD_W-1:0] x_sh1,
    input logic [WORD_W-1:0] x_sh2,
    input logic [WORD_W-1:0] x_sh3,
    input logic [WORD_W-1:0] y_sh1,
    input logic [WORD_W-1:0] y_sh2,
    input logic [WORD_W-1:0] y_sh3,
    input logic              prod_valid,
    input logic [WORD_W-1:0] prod_sh1,
    input logic [WORD_W-1:0] prod_sh2,
    input logic [WORD_W-1:0] prod_sh3,
    input logic              done,
    input logic [CNT_W-1:0]  total_a,
    input logic [CNT_W-1:0]  total_b
);

    localparam int PC_W = $clog2(NUM_WORDS + 1) + 1;

    logic [PC_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (done)
            seen <= prod_valid ? PC_W'(1) : '0;
        else if (prod_valid)
            seen <= seen + PC_W'(1);
    end

    AST_AND_RECOMBINE: assert property (@(posedge clk) disable iff (rst)
        take_word |=> prod_valid &&
            ((prod_sh1 ^ prod_sh2 ^ prod_sh3) ==
             ($past(x_sh1 ^ x_sh2 ^ x_sh3) & $past(y_sh1 ^ y_sh2 ^ y_sh3)))); // R2

    AST_NO_SPURIOUS_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        !take_word |=> !prod_valid); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen == PC_W'(NUM_WORDS))); // R4

    AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(total_a) && $stable(total_b))); // R7

endmodule

bind masked_and_weight masked_and_weight_chk #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .take_word  (take_word),
    .x_sh1      (x_sh1),
    .x_sh2      (x_sh2),
    .x_sh3      (x_sh3),
    .y_sh1      (y_sh1),
    .y_sh2      (y_sh2),
    .y_sh3      (y_sh3),
    .prod_valid (prod_valid),
    .prod_sh1   (prod_sh1),
    .prod_sh2   (prod_sh2),
    .prod_sh3   (prod_sh3),
    .done       (done),
    .total_a    (total_a),
    .total_b    (total_b)
);

// File: tb/masked_and_weight_test.sv
module masked_and_weight_test;

    localparam int W  = 32;
    localparam int CW = 6;
    localparam int NW = 150;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [W-1:0]    x_sh1 = '0, x_sh2 = '0, x_sh3 = '0;
    logic [W-1:0]    y_sh1 = '0, y_sh2 = '0, y_sh3 = '0;
    logic [1:0]      fresh_bits = '0;
    logic [W*CW-1:0] conv_rnd = '0;
    logic            prod_valid;
    logic [W-1:0]    prod_sh1, prod_sh2, prod_sh3;
    logic            done;
    logic [CW-1:0]   total_a, total_b;

    always #2 clk = ~clk;

    masked_and_weight uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_sh1(x_sh1), .x_sh2(x_sh2), .x_sh3(x_sh3),
        .y_sh1(y_sh1), .y_sh2(y_sh2), .y_sh3(y_sh3),
        .fresh_bits(fresh_bits), .conv_rnd(conv_rnd),
        .prod_valid(prod_valid), .prod_sh1(prod_sh1),
        .prod_sh2(prod_sh2), .prod_sh3(prod_sh3),
        .done(done), .total_a(total_a), .total_b(total_b)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [W-1:0] q1[$], q2[$], q3[$];
    int           qw[$];
    bit           qz[$];
    logic         cb1 = 1'b0, cb2 = 1'b0;
    bit           rnd_zero = 0;
    int           run_weight;

    task automatic report(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_conv();
        for (int k = 0; k < CW; k++)
            conv_rnd[k*W +: W] = rnd_zero ? '0 : $urandom;
    endtask

    // drive one word; push expected shares when it is to be accepted
    task automatic drive(input logic [W-1:0] tx, input logic [W-1:0] ty,
                         input bit valid, input bit expect_take);
        logic [W-1:0] a1, a2, a3, b1, b2, b3, f1, f2, f3, r1, r2;
        logic [1:0]   fr;
        @(posedge clk); #1;
        a1 = $urandom; a2 = $urandom; a3 = tx ^ a1 ^ a2;
        b1 = $urandom; b2 = $urandom; b3 = ty ^ b1 ^ b2;
        fr = 2'($urandom);
        x_sh1 = a1; x_sh2 = a2; x_sh3 = a3;
        y_sh1 = b1; y_sh2 = b2; y_sh3 = b3;
        fresh_bits = fr;
        in_valid = valid;
        set_conv();
        if (valid && expect_take) begin
            f1 = (a2 & b2) ^ (a2 & b3) ^ (a3 & b2);
            f2 = (a3 & b3) ^ (a1 & b3) ^ (a3 & b1);
            f3 = (a1 & b1) ^ (a1 & b2) ^ (a2 & b1);
            r1 = {b2[W-2:0], cb1 ^ fr[0]};
            r2 = {b3[W-2:0], cb2 ^ fr[1]};
            q1.push_back(f1 ^ r1);
            q2.push_back(f2 ^ r2);
            q3.push_back(f3 ^ r1 ^ r2);
            cb1 = b2[W-1];
            cb2 = b3[W-1];
            run_weight += $countones(tx & ty);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0;
        x_sh1 = $urandom; y_sh1 = $urandom;
        set_conv();
    endtask

    // mode 0 sparse random, 1 weight 45, 2 weight 0
    task automatic run(input int mode, input bit gaps, input bit late_strobes, input bit zero_rnd);
        logic [W-1:0] tx, ty;
        rnd_zero = zero_rnd;
        run_weight = 0;
        for (int i = 0; i < NW; i++) begin
            if (gaps && ($urandom % 3 == 0)) idle();
            case (mode)
                1: begin tx = '1; ty = (i < 45) ? (32'd1 << (i % W)) : '0; end
                2: begin tx = $urandom; ty = '0; end
                default: begin tx = $urandom; ty = (i % 4 == 0) ? (32'd1 << ($urandom % W)) : '0; end
            endcase
            drive(tx, ty, 1'b1, 1'b1);
        end
        qw.push_back(run_weight % 64);
        qz.push_back(zero_rnd);
        if (late_strobes) begin
            drive($urandom, '1, 1'b1, 1'b0);   // R6: closing edge 1
            drive($urandom, '1, 1'b1, 1'b0);   // R6: closing edge 2
        end
        for (int k = 0; k < 5; k++) idle();
        rnd_zero = 0;
    endtask

    // monitor / scoreboard
    logic [CW-1:0] last_a = '0, last_b = '0;
    bit            prev_done = 0;
    int            cycles = 0;
    int            close_cnt = -1;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            cycles++;
            if (prod_valid) begin
                if (q1.size() == 0) begin
                    report(0, "R6", 1, 0);
                end else begin
                    logic [W-1:0] e1, e2, e3;
                    e1 = q1.pop_front(); e2 = q2.pop_front(); e3 = q3.pop_front();
                    report(prod_sh1 == e1, "R3 sh1", prod_sh1, e1);
                    report(prod_sh2 == e2, "R3 sh2", prod_sh2, e2);
                    report(prod_sh3 == e3, "R3 sh3", prod_sh3, e3);
                    report((prod_sh1 ^ prod_sh2 ^ prod_sh3) == (e1 ^ e2 ^ e3), "R2",
                           prod_sh1 ^ prod_sh2 ^ prod_sh3, e1 ^ e2 ^ e3);
                end
            end
            if (done) begin
                report(!prev_done, "R4 pulse", 1, 0);
                if (qw.size() == 0) begin
                    report(0, "R4 unexpected done", 1, 0);
                end else begin
                    int  ew;
                    bit  z;
                    ew = qw.pop_front();
                    z  = qz.pop_front();
                    report(6'(total_a + total_b) == 6'(ew), "R4 R5 R9 weight",
                           6'(total_a + total_b), ew);
                    if (z) begin
                        report(total_a == 0, "R8 share a", total_a, 0);
                        report(total_b == 6'(ew), "R8 share b", total_b, ew);
                    end
                end
            end else begin
                report(total_a == last_a && total_b == last_b, "R7",
                       {total_a, total_b}, {last_a, last_b});
            end
            last_a = total_a;
            last_b = total_b;
            prev_done = done;
            if (cycles > 60000) begin
                report(0, "watchdog", cycles, 0);
                finished = 1;
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        report(done == 0, "R1 done", done, 0);
        report(prod_valid == 0, "R1 prod_valid", prod_valid, 0);
        report(total_a == 0, "R1 total_a", total_a, 0);
        report(total_b == 0, "R1 total_b", total_b, 0);

        run(0, 0, 0, 1);   // R8 zero conversion randomness
        run(0, 1, 1, 0);   // R5 gaps, R6 late strobes
        run(1, 0, 0, 0);   // boundary weight 45
        run(2, 1, 0, 0);   // weight 0
        run(0, 0, 1, 1);   // R9 back-to-back independence

        for (int k = 0; k < 5; k++) idle();
        report(q1.size() == 0, "R2 pending products", q1.size(), 0);
        report(qw.size() == 0, "R4 pending totals", qw.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule